// File: doc/BRIEF.md
# Ordered Barrier Sequencer

This block synchronises a group of processors through barriers that fire in one fixed global order. A control port fills a queue with entries. Each entry pairs a participant mask, in which bit i stands for processor i, with a return word. A processor reaches the sequencer by reading a decoded barrier address, which raises its request line. The read is held with wait states until the entry at the head of the queue finds every one of its participants waiting. At that point the head entry fires. All of its participants are released in the same cycle with the entry's return word, and the entry is removed from the queue.

A data read that lands in the barrier region uses the read only to synchronise and drops the word. An instruction-fetch read takes the word as the next broadcast instruction, so a processor that fetches from the barrier region runs in lockstep with its group. The sequencer delivers the word the same way in both cases. The kind of read only updates a per-processor status bit that shows which processors were last released from a fetch.

Top module: `barrier_sequencer`

## Requirements
- R1: After reset, barReady, lockstepMode and queueFull are all 0 and the queue is empty.
- R2: When every processor in the head entry's mask holds barReq high, barReady equals exactly that mask for one cycle on the next clock edge. In that same cycle retWord holds the entry's word. A processor is not released again in the cycle it is being released.
- R3: Entries fire strictly in push order. An entry whose participants are all waiting stays unreleased while an earlier entry is still queued.
- R4: A processor that requests while it is not in the head mask stays stalled (barReady bit 0) until an entry that includes it reaches the head. Its extra request does not stop the head from firing.
- R5: While the queue is empty, no barReady bit is asserted, whatever the requests.
- R6: queueFull is 1 exactly when DEPTH entries are queued. A push offered while queueFull is 1 is discarded.
- R7: A push whose mask is all zeros is discarded and takes no queue slot.
- R8: A push and a release in the same cycle both take effect. The occupancy is unchanged and the new entry keeps its place at the tail.
- R9: fetchKind bit i (1 = instruction fetch, 0 = data read) does not change barReady or retWord. On release, lockstepMode bit i takes the value of fetchKind bit i. Bits of processors that are not released keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Control port offers an entry |
| pushMask | input | NUM_PROC | Participant mask of the offered entry |
| pushWord | input | WORD_W | Return word of the offered entry |
| queueFull | output | 1 | Queue holds DEPTH entries; pushes are refused |
| barReq | input | NUM_PROC | Processor i is stalled on a barrier read |
| fetchKind | input | NUM_PROC | Processor i's barrier read is an instruction fetch |
| barReady | output | NUM_PROC | Release pulse ending processor i's wait states |
| retWord | output | WORD_W | Return word of the entry released last |
| lockstepMode | output | NUM_PROC | Processor i was last released from a fetch read |

## Verification
A control-port push and a head release can land on the same clock edge. The bench provokes this by holding three entries, then raising the last missing request of the head entry at the same cycle it offers a new entry. It judges the outcome at the ports. The released word must be the head's word, and queueFull must stay low until exactly one more push. A full drain must then return the remaining words, including the one pushed in the shared cycle, in push order.

// File: rtl/barrier_seq_pkg.sv
package barrier_seq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic push;  // write pushMask/pushWord at the tail
    logic pop;   // head entry fires: latch its word, advance head
  } seqStrobes_t;

endpackage

// File: rtl/barrier_seq_dp.sv
module barrier_seq_dp
  import barrier_seq_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int WORD_W   = 32,
  parameter int DEPTH    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic [NUM_PROC-1:0] pushMask,
  input  logic [WORD_W-1:0]   pushWord,
  output logic [NUM_PROC-1:0] headMask,
  output logic [WORD_W-1:0]   retWord
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [NUM_PROC-1:0] maskMem [DEPTH];
  logic [WORD_W-1:0]   wordMem [DEPTH];
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      maskMem[wrPtr] <= pushMask;
      wordMem[wrPtr] <= pushWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      retWord <= '0;
    end else begin
      if (strobes.push) wrPtr <= stepPtr(wrPtr);
      if (strobes.pop) begin
        rdPtr   <= stepPtr(rdPtr);
        retWord <= wordMem[rdPtr];
      end
    end
  end

  assign headMask = maskMem[rdPtr];

endmodule

// File: rtl/barrier_seq_ctrl.sv
module barrier_seq_ctrl
  import barrier_seq_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int DEPTH    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic [NUM_PROC-1:0] pushMask,
  input  logic [NUM_PROC-1:0] barReq,
  input  logic [NUM_PROC-1:0] fetchKind,
  input  logic [NUM_PROC-1:0] headMask,
  output seqStrobes_t         strobes,
  output logic [NUM_PROC-1:0] barReady,
  output logic [NUM_PROC-1:0] lockstepMode,
  output logic                queueFull,
  output logic                queueEmpty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0]    occupancy;
  logic [NUM_PROC-1:0] waitSet;
  logic                fire;
  logic                acceptPush;

  assign queueFull  = (occupancy == CNT_MAX);
  assign queueEmpty = (occupancy == '0);

  // a processor being released this cycle is not counted as waiting
  assign waitSet    = barReq & ~barReady;
  assign fire       = !queueEmpty && ((headMask & ~waitSet) == '0);
  assign acceptPush = pushValid && !queueFull && (pushMask != '0);

  assign strobes.push = acceptPush;
  assign strobes.pop  = fire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occupancy <= '0;
    end else if (acceptPush && !fire) begin
      occupancy <= occupancy + CNT_W'(1);
    end else if (fire && !acceptPush) begin
      occupancy <= occupancy - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) barReady <= '0;
    else       barReady <= fire ? headMask : '0;
  end

  for (genvar g = 0; g < NUM_PROC; g++) begin : gLock
    always_ff @(posedge clk) begin
      if (!rstN)                  lockstepMode[g] <= 1'b0;
      else if (fire && headMask[g]) lockstepMode[g] <= fetchKind[g];
    end
  end

endmodule

// File: rtl/barrier_sequencer.sv
module barrier_sequencer
  import barrier_seq_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int WORD_W   = 32,
  parameter int DEPTH    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic [NUM_PROC-1:0] pushMask,
  input  logic [WORD_W-1:0]   pushWord,
  output logic                queueFull,
  input  logic [NUM_PROC-1:0] barReq,
  input  logic [NUM_PROC-1:0] fetchKind,
  output logic [NUM_PROC-1:0] barReady,
  output logic [WORD_W-1:0]   retWord,
  output logic [NUM_PROC-1:0] lockstepMode
);
  seqStrobes_t         strobes;
  logic [NUM_PROC-1:0] headMask;
  logic                queueEmpty;

  barrier_seq_ctrl #(.NUM_PROC(NUM_PROC), .DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .pushValid    (pushValid),
    .pushMask     (pushMask),
    .barReq       (barReq),
    .fetchKind    (fetchKind),
    .headMask     (headMask),
    .strobes      (strobes),
    .barReady     (barReady),
    .lockstepMode (lockstepMode),
    .queueFull    (queueFull),
    .queueEmpty   (queueEmpty)
  );

  barrier_seq_dp #(.NUM_PROC(NUM_PROC), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pushMask (pushMask),
    .pushWord (pushWord),
    .headMask (headMask),
    .retWord  (retWord)
  );

endmodule

// File: rtl/barrier_sequencer_checker.sv
module barrier_sequencer_checker
  import barrier_seq_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int WORD_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PROC-1:0] barReq,
  input logic [NUM_PROC-1:0] barReady,
  input logic [WORD_W-1:0]   retWord,
  input logic                queueFull,
  input logic                queueEmpty,
  input seqStrobes_t         strobes
);

  assert_release_waiting_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|barReady) |-> ((barReady & ~$past(barReq)) == '0));

  assert_no_double_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|barReady) |=> ((barReady & $past(barReady)) == '0));

  assert_release_needs_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|barReady) |-> $past(!queueEmpty));

  assert_full_blocks_push_R6: assert property (@(posedge clk) disable iff (!rstN)
    queueFull |-> !strobes.push);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({queueFull, queueEmpty}));

  assert_word_moves_on_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(retWord) |-> (|barReady));

endmodule

bind barrier_sequencer barrier_sequencer_checker #(
  .NUM_PROC(NUM_PROC), .WORD_W(WORD_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .barReq     (barReq),
  .barReady   (barReady),
  .retWord    (retWord),
  .queueFull  (queueFull),
  .queueEmpty (queueEmpty),
  .strobes    (strobes)
);

// File: tb/barrier_sequencer_bench.sv
module barrier_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int WW  = 32;
  localparam int DEP = 4;
  localparam int NVEC = 5;

  // vector table: mask (also the request pattern), return word, fetch pattern
  localparam logic [NP-1:0] V_MASK  [NVEC] = '{4'b0011, 4'b1111, 4'b0100, 4'b1010, 4'b0001};
  localparam logic [WW-1:0] V_WORD  [NVEC] = '{32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'h8000_0001};
  localparam logic [NP-1:0] V_FETCH [NVEC] = '{4'b0001, 4'b1111, 4'b0000, 4'b1000, 4'b0000};

  logic clk = 0;
  logic rstN = 0;
  logic pushValid = 0;
  logic [NP-1:0] pushMask = '0;
  logic [WW-1:0] pushWord = '0;
  logic queueFull;
  logic [NP-1:0] barReq = '0;
  logic [NP-1:0] fetchKind = '0;
  logic [NP-1:0] barReady;
  logic [WW-1:0] retWord;
  logic [NP-1:0] lockstepMode;

  int checks = 0;
  int fails = 0;
  logic [NP-1:0] expLock = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrier_sequencer #(.NUM_PROC(NP), .WORD_W(WW), .DEPTH(DEP)) u_barrier_sequencer (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushMask(pushMask),
    .pushWord(pushWord), .queueFull(queueFull), .barReq(barReq),
    .fetchKind(fetchKind), .barReady(barReady), .retWord(retWord),
    .lockstepMode(lockstepMode)
  );

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushEntry(input logic [NP-1:0] m, input logic [WW-1:0] w);
    pushValid = 1; pushMask = m; pushWord = w;
    @(negedge clk);
    pushValid = 0; pushMask = '0; pushWord = '0;
  endtask

  task automatic waitRelease(output logic [NP-1:0] got, output logic [WW-1:0] w);
    got = '0; w = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (|barReady) begin
        got = barReady; w = retWord;
        break;
      end
    end
  endtask

  task automatic idleNoRelease(input int n, input string tag);
    logic seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (|barReady) seen = 1;
    end
    check(!seen, tag, {28'd0, barReady}, '0);
  endtask

  task automatic drainOne(input logic [NP-1:0] m, input logic [WW-1:0] w, input string tag);
    logic [NP-1:0] got;
    logic [WW-1:0] gw;
    barReq = m;
    waitRelease(got, gw);
    check(got == m, tag, {28'd0, got}, {28'd0, m});
    check(gw == w, tag, gw, w);
    barReq = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [NP-1:0] got;
    logic [WW-1:0] gw;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(barReady == '0 && lockstepMode == '0 && queueFull == 0, "R1 reset outputs",
          {24'd0, barReady, lockstepMode}, '0);
    rstN = 1;
    @(negedge clk);

    // R5: empty queue never releases
    barReq = '1;
    idleNoRelease(5, "R5 empty queue released");
    barReq = '0;
    @(negedge clk);

    // table walk: R2 release and word, R9 fetch status
    for (int v = 0; v < NVEC; v++) begin
      pushEntry(V_MASK[v], V_WORD[v]);
      fetchKind = V_FETCH[v];
      barReq = V_MASK[v];
      waitRelease(got, gw);
      check(got == V_MASK[v], "R2 release mask", {28'd0, got}, {28'd0, V_MASK[v]});
      check(gw == V_WORD[v], "R2/R9 return word", gw, V_WORD[v]);
      expLock = (expLock & ~V_MASK[v]) | (V_FETCH[v] & V_MASK[v]);
      check(lockstepMode == expLock, "R9 lockstep status", {28'd0, lockstepMode}, {28'd0, expLock});
      barReq = '0;
      @(negedge clk);
      check(barReady == '0, "R2 single-cycle release", {28'd0, barReady}, '0);
    end
    fetchKind = '0;

    // R3: later entry fully waiting must not overtake head
    pushEntry(4'b0011, 32'hAAAA_0000);
    pushEntry(4'b1100, 32'hBBBB_0000);
    barReq = 4'b1100;
    idleNoRelease(4, "R3 later entry fired early");
    barReq = 4'b1111;
    waitRelease(got, gw);
    check(got == 4'b0011 && gw == 32'hAAAA_0000, "R3 head first", gw, 32'hAAAA_0000);
    barReq = 4'b1100;
    @(negedge clk);
    check(barReady == 4'b1100 && retWord == 32'hBBBB_0000, "R3 second in order", retWord, 32'hBBBB_0000);
    barReq = '0;
    @(negedge clk);

    // R4: non-participant request stays stalled
    pushEntry(4'b0001, 32'hC0C0_0001);
    barReq = 4'b0010;
    idleNoRelease(4, "R4 non-member released");
    barReq = 4'b0011;
    waitRelease(got, gw);
    check(got == 4'b0001, "R4 only head member released", {28'd0, got}, 32'h1);
    barReq = 4'b0010;
    idleNoRelease(4, "R4 stalled proc released");
    barReq = '0;
    @(negedge clk);

    // R7 and R6: zero mask discarded, full at DEPTH, push while full dropped
    pushEntry(4'b0000, 32'h0000_00FF);
    for (int i = 0; i < DEP - 1; i++) pushEntry(4'b1000, 32'hF000_0000 + i);
    check(queueFull == 0, "R7 zero mask took a slot", {31'd0, queueFull}, 0);
    pushEntry(4'b1000, 32'hF000_0000 + DEP - 1);
    check(queueFull == 1, "R6 full at depth", {31'd0, queueFull}, 1);
    pushEntry(4'b1000, 32'h7777_7777);
    for (int i = 0; i < DEP; i++) drainOne(4'b1000, 32'hF000_0000 + i, "R6 drain order");
    barReq = 4'b1000;
    idleNoRelease(4, "R6 push while full kept");
    barReq = '0;
    @(negedge clk);

    // R8: push and release in the same cycle
    pushEntry(4'b0001, 32'h1111_0001);
    pushEntry(4'b0001, 32'h1111_0002);
    pushEntry(4'b0001, 32'h1111_0003);
    barReq = 4'b0001;
    pushValid = 1; pushMask = 4'b0010; pushWord = 32'h1111_0004;
    @(negedge clk);
    pushValid = 0; pushMask = '0; pushWord = '0;
    check(barReady == 4'b0001 && retWord == 32'h1111_0001, "R8 release in shared cycle", retWord, 32'h1111_0001);
    barReq = '0;
    check(queueFull == 0, "R8 occupancy kept", {31'd0, queueFull}, 0);
    pushEntry(4'b0100, 32'h1111_0005);
    check(queueFull == 1, "R8 one more fills", {31'd0, queueFull}, 1);
    drainOne(4'b0001, 32'h1111_0002, "R8 drain");
    drainOne(4'b0001, 32'h1111_0003, "R8 drain");
    drainOne(4'b0010, 32'h1111_0004, "R8 shared-cycle entry");
    drainOne(4'b0100, 32'h1111_0005, "R8 drain");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule